// File: doc/BRIEF.md
# Dual-Channel Fine-Resolution Pulse Width Modulator

This block drives two pulse width modulated outputs with 14-bit effective duty resolution. It uses an 8-bit compare against a free-running frame counter. A shared 14-bit up-counter advances once per prescaled clock. Its low byte walks through a 256-clock frame, and each channel's output is high for the first `duty` clocks of that frame. The upper six counter bits number the frames of a 64-frame super-cycle. A 6-bit extension value per channel chooses how many of those 64 frames carry one extra high clock. Averaged over a super-cycle, the duty therefore reaches 1/16384 steps.

Software programs the block through a small synchronous register port. Address 0 is the control register: run bit at bit 0, output enables for channel 0 and channel 1 at bits 1 and 2, and a 3-bit prescaler code at bits 7..5. Bits 4..3 are unused and read 0. Channel `k` has its base duty at address `1+2k` and its extension register at address `2+2k`. In the extension register the 6-bit value sits in bits 7..2. Clearing the run bit freezes the counter and the prescaler where they stand, and setting it again continues from there. While the counter runs, duty and extension writes are staged and applied at the next frame start. While it is stopped they apply at once.

Top module: `stretch_pwm`

## Requirements
- R1: After a synchronous active-high reset, both outputs are low, every register reads 0 and the counter is 0.
- R2: Register reads return the stored value one clock after the address is presented. Control reads back as {prescaler[7:5], 00, enable1[2], enable0[1], run[0]}. An extension register reads back its 6-bit value in bits 7..2 with bits 1..0 as 0, and writes to bits 1..0 have no effect on the output.
- R3: With extension 0, each channel's output is high for exactly `duty` counter clocks in every 256-clock frame. A duty of 0 keeps the output low.
- R4: Frame `f` (upper counter bits) of a channel is stretched to `duty+1` high clocks when the extension value exceeds the 6-bit bit-reversal of `f`. So exactly `ext` of 64 frames are stretched, and the high total over 16384 counter clocks is 64*duty+ext.
- R5: The counter advances once every code+1 system clocks, where code is the 3-bit prescaler field. Every duration scales by that factor.
- R6: While run is 0 the counter and prescaler hold their values and the outputs stay constant. Setting run again resumes from the held count, so the running pulse is lengthened by exactly the stopped time.
- R7: A channel whose enable bit is 0 drives its output low, and this does not affect the other channel.
- R8: While running, a new duty or extension value takes effect only at the next frame start. The pulse in progress keeps its old width.
- R9: The two channels use one counter but independent duty and extension settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| pwm_out | output | 2 | Registered PWM outputs, bit k for channel k |

## Verification
The assertions assume reset is high at time zero and through the first clock edge. They also assume every write is a single-cycle strobe sampled on the rising edge. Given that, the counter only ever steps by one or holds, and the outputs' previous-cycle relation to the count holds from the first edge after reset. The stimulus keeps reset asserted for several clocks at start. It changes inputs only on falling edges, lets at least two frames pass after each reconfiguration before measuring, and starts pulse-count windows on a rising output edge so that every counted pulse lies wholly inside the window.

// File: rtl/stretch_pwm_pkg.sv
package stretch_pwm_pkg;

  localparam int RUN_POS = 0;
  localparam int EN_POS  = 1;
  localparam int CTRL_ADDR = 0;

  function automatic int duty_addr(input int ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int ext_addr(input int ch);
    return 2 + 2 * ch;
  endfunction

endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import stretch_pwm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int XW  = 6,
  parameter int PW  = 3,
  parameter int AW  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     run,
  output logic [NCH-1:0]           out_en,
  output logic [PW-1:0]            presc,
  output logic [NCH-1:0][DW-1:0]   duty,
  output logic [NCH-1:0][XW-1:0]   ext
);

  localparam int PAD = DW - XW;

  logic [DW-1:0] rd_next;

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      out_en <= '0;
      presc  <= '0;
    end else if (we && addr == AW'(CTRL_ADDR)) begin
      run    <= wdata[RUN_POS];
      out_en <= wdata[EN_POS +: NCH];
      presc  <= wdata[DW-1 -: PW];
    end
  end

  // per-channel data and extension registers
  for (genvar i = 0; i < NCH; i++) begin : g_chreg
    always_ff @(posedge clk) begin
      if (rst) begin
        duty[i] <= '0;
        ext[i]  <= '0;
      end else if (we) begin
        if (addr == AW'(duty_addr(i))) duty[i] <= wdata;
        if (addr == AW'(ext_addr(i)))  ext[i]  <= wdata[DW-1 -: XW];
      end
    end
  end

  // readback mux
  always_comb begin
    rd_next = '0;
    if (addr == AW'(CTRL_ADDR)) begin
      rd_next[RUN_POS]         = run;
      rd_next[EN_POS +: NCH]   = out_en;
      rd_next[DW-1 -: PW]      = presc;
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(duty_addr(i))) rd_next = duty[i];
      if (addr == AW'(ext_addr(i)))  rd_next = {ext[i], {PAD{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
  parameter int DW = 8,
  parameter int XW = 6,
  parameter int PW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PW-1:0]     presc,
  output logic [DW+XW-1:0]  cnt,
  output logic              frame_load
);

  localparam int CW = DW + XW;

  logic [PW-1:0] pre_cnt;
  logic          tick;

  // >= so that lowering the code mid-count cannot skip a wrap
  assign tick = run && (pre_cnt >= presc);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (run) begin
      if (tick) begin
        pre_cnt <= '0;
        cnt     <= cnt + CW'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end

  // shadows follow live values while stopped, else only at frame wrap
  assign frame_load = !run || (tick && (&cnt[DW-1:0]));

endmodule

// File: rtl/spwm_chan.sv
module spwm_chan #(
  parameter int DW = 8,
  parameter int XW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DW+XW-1:0]  cnt,
  input  logic [DW-1:0]     duty,
  input  logic [XW-1:0]     ext,
  input  logic              en,
  output logic [DW-1:0]     duty_sh,
  output logic              pwm
);

  logic [XW-1:0] ext_sh;
  logic [XW-1:0] frame_rev;
  logic [DW-1:0] lo;
  logic          stretch;
  logic          high;

  assign lo = cnt[DW-1:0];

  for (genvar b = 0; b < XW; b++) begin : g_rev
    assign frame_rev[b] = cnt[DW+XW-1-b];
  end

  assign stretch = ext_sh > frame_rev;
  assign high    = (lo < duty_sh) || (stretch && (lo == duty_sh));

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_sh <= '0;
      ext_sh  <= '0;
      pwm     <= 1'b0;
    end else begin
      if (load) begin
        duty_sh <= duty;
        ext_sh  <= ext;
      end
      pwm <= en & high;
    end
  end

endmodule

// File: rtl/stretch_pwm.sv
module stretch_pwm #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int XW  = 6,
  parameter int PW  = 3,
  localparam int AW = $clog2(2 * NCH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NCH-1:0]  pwm_out
);

  localparam int CW = DW + XW;

  logic                    run;
  logic [NCH-1:0]          out_en;
  logic [PW-1:0]           presc;
  logic [NCH-1:0][DW-1:0]  duty;
  logic [NCH-1:0][XW-1:0]  ext;
  logic [NCH-1:0][DW-1:0]  duty_sh;
  logic [CW-1:0]           cnt;
  logic                    frame_load;

  spwm_regs #(.NCH(NCH), .DW(DW), .XW(XW), .PW(PW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .run    (run),
    .out_en (out_en),
    .presc  (presc),
    .duty   (duty),
    .ext    (ext)
  );

  spwm_timebase #(.DW(DW), .XW(XW), .PW(PW)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .presc      (presc),
    .cnt        (cnt),
    .frame_load (frame_load)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    spwm_chan #(.DW(DW), .XW(XW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .load    (frame_load),
      .cnt     (cnt),
      .duty    (duty[i]),
      .ext     (ext[i]),
      .en      (out_en[i]),
      .duty_sh (duty_sh[i]),
      .pwm     (pwm_out[i])
    );
  end

endmodule

// File: rtl/stretch_pwm_chk.sv
module stretch_pwm_chk #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int XW  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NCH-1:0]          pwm_out,
  input logic                    run,
  input logic [NCH-1:0]          out_en,
  input logic [DW+XW-1:0]        cnt,
  input logic [NCH-1:0][DW-1:0]  duty_sh
);

  localparam int CW = DW + XW;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pwm_out == '0));

  // R6
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == CW'($past(cnt) + CW'(1))));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R7
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !out_en[i] |=> !pwm_out[i]);

    // R3
    duty_bound_chk: assert property (@(posedge clk) disable iff (rst)
      pwm_out[i] |-> ($past(cnt[DW-1:0]) <= $past(duty_sh[i])));

    // R8
    frame_update_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(run) && !$stable(duty_sh[i])) |-> (cnt[DW-1:0] == '0));
  end

endmodule

bind stretch_pwm stretch_pwm_chk #(.NCH(NCH), .DW(DW), .XW(XW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwm_out (pwm_out),
  .run     (run),
  .out_en  (out_en),
  .cnt     (cnt),
  .duty_sh (duty_sh)
);

// File: tb/tb_stretch_pwm.sv
module tb_stretch_pwm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] pwm_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    ch;
    int    cycles;
    int    exp_high;
    int    exp_long;
    int    long_len;
    bit    sync;
    string tag;
  } win_t;

  win_t sbq[$];

  stretch_pwm dut (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ctrl(input int p, input int en, input int run);
    return 8'((p << 5) | (en << 1) | run);
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called right after a falling edge; does not consume a sample slot
  task automatic wr(input int a, input int d, output int at_cyc);
    reg_addr  = 3'(a);
    reg_wdata = 8'(d);
    reg_we    = 1'b1;
    @(posedge clk);
    #1;
    at_cyc = cyc;
    reg_we = 1'b0;
  endtask

  task automatic wr_wait(input int a, input int d);
    int c;
    @(negedge clk);
    wr(a, d, c);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    @(posedge clk);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push one expected window and wait until the monitor consumed it
  task automatic expect_win(input int ch, input int cycles, input int hi,
                            input int lp, input int ll, input bit sync,
                            input string tag);
    win_t w;
    w.ch = ch; w.cycles = cycles; w.exp_high = hi;
    w.exp_long = lp; w.long_len = ll; w.sync = sync; w.tag = tag;
    sbq.push_back(w);
    wait (sbq.size() == 0);
  endtask

  // monitor
  initial begin
    forever begin
      win_t w;
      int hi, lp, len, guard;
      bit prev, cur, ok;
      wait (sbq.size() > 0);
      w = sbq[0];
      hi = 0; lp = 0; len = 0; ok = 1;
      @(negedge clk);
      cur = pwm_out[w.ch];
      if (w.sync) begin
        guard = 0;
        prev = cur;
        while (!(prev == 1'b0 && cur == 1'b1) && guard < 20000) begin
          prev = cur;
          @(negedge clk);
          cur = pwm_out[w.ch];
          guard++;
        end
        if (guard >= 20000) ok = 0;
      end
      for (int k = 0; k < w.cycles; k++) begin
        if (k > 0) begin
          @(negedge clk);
          cur = pwm_out[w.ch];
        end
        if (cur) begin
          hi++;
          len++;
        end else begin
          if (len == w.long_len && len > 0) lp++;
          len = 0;
        end
      end
      if (!ok) check(0, 1, {w.tag, " no rising edge"});
      check(hi, w.exp_high, {w.tag, " high total"});
      if (w.exp_long >= 0) check(lp, w.exp_long, {w.tag, " stretched pulses"});
      void'(sbq.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, h, cA, cB, lows;
    settle(5);
    rst = 1'b0;
    settle(2);

    // R1 reset state
    check(int'(pwm_out), 0, "R1 outputs after reset");
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check(v, 0, "R1 register after reset");
    end

    // configure both channels, then start
    wr_wait(1, 77);
    wr_wait(2, 8'h03);          // only ignored low bits set
    wr_wait(3, 30);
    wr_wait(4, 8'h40);
    wr_wait(0, ctrl(0, 3, 1));

    // R2 readback
    rd(0, v); check(v, 8'h07, "R2 control readback");
    rd(2, v); check(v, 8'h00, "R2 ext low bits dropped");
    rd(4, v); check(v, 8'h40, "R2 ext readback");
    rd(1, v); check(v, 77, "R2 duty readback");
    wr_wait(0, ctrl(5, 3, 1));
    rd(0, v); check(v, 8'hA7, "R2 prescaler field readback");
    wr_wait(0, ctrl(0, 3, 1));
    settle(600);

    // R3 base duty, ext bits 1..0 have no effect (R2)
    expect_win(0, 16384, 64 * 77, 0, 78, 1, "R3 duty77");

    // R3 zero duty
    wr_wait(1, 0);
    wr_wait(2, 0);
    settle(600);
    expect_win(0, 1000, 0, -1, 0, 0, "R3 duty0");

    // R4 stretch patterns
    wr_wait(1, 100);
    wr_wait(2, 32 << 2);
    settle(600);
    expect_win(0, 16384, 64 * 100 + 32, 32, 101, 1, "R4 d100 e32");

    wr_wait(1, 0);
    wr_wait(2, 5 << 2);
    settle(600);
    expect_win(0, 16384, 5, 5, 1, 1, "R4 d0 e5");

    wr_wait(1, 255);
    wr_wait(2, 63 << 2);
    settle(600);
    expect_win(0, 16384, 64 * 255 + 63, -1, 0, 0, "R4 d255 e63");

    // R9 independent channels
    wr_wait(1, 60);
    wr_wait(2, 10 << 2);
    wr_wait(3, 200);
    wr_wait(4, 50 << 2);
    settle(600);
    expect_win(1, 16384, 64 * 200 + 50, 50, 201, 1, "R9 ch1");
    expect_win(0, 16384, 64 * 60 + 10, 10, 61, 1, "R9 ch0");

    // R7 output enable
    wr_wait(0, ctrl(0, 2, 1));
    settle(4);
    fork
      expect_win(0, 2000, 0, -1, 0, 0, "R7 ch0 disabled");
      begin
        h = 0;
        repeat (2000) begin
          @(negedge clk);
          if (pwm_out[1]) h++;
        end
      end
    join
    check(int'(h > 0), 1, "R7 ch1 unaffected");
    wr_wait(0, ctrl(0, 3, 1));

    // R8 staged update while running
    wr_wait(1, 100);
    wr_wait(2, 0);
    settle(600);
    while (pwm_out[0]) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    h = 0;
    while (pwm_out[0]) begin
      h++;
      if (h == 50) wr(1, 20, cA);
      @(negedge clk);
    end
    check(h, 100, "R8 pulse in progress keeps old duty");
    while (!pwm_out[0]) @(negedge clk);
    h = 0;
    while (pwm_out[0]) begin
      h++;
      @(negedge clk);
    end
    check(h, 20, "R8 new duty at next frame");

    // R6 stop and resume mid-pulse
    wr_wait(1, 100);
    settle(600);
    while (pwm_out[0]) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    h = 0;
    lows = 0;
    cA = 0;
    cB = 0;
    while (pwm_out[0]) begin
      h++;
      if (h == 30) begin
        wr(0, ctrl(0, 3, 0), cA);
        repeat (200) begin
          @(negedge clk);
          if (pwm_out[0]) h++;
          else lows++;
        end
        wr(0, ctrl(0, 3, 1), cB);
      end
      @(negedge clk);
    end
    check(lows, 0, "R6 output held while stopped");
    check(h, 100 + (cB - cA), "R6 pulse resumes from held count");

    // R5 prescaler divide by 2
    wr_wait(0, ctrl(1, 3, 1));
    wr_wait(1, 50);
    wr_wait(2, 20 << 2);
    settle(1200);
    expect_win(0, 32768, 2 * (64 * 50 + 20), 20, 102, 1, "R5 div2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule